// File: doc/BRIEF.md
# Streaming WebSocket Frame Header Decoder and Unmasker

This block sits on a byte stream carrying WebSocket frames. It parses the variable-length header of each frame, publishes the decoded header on a set of sideband pins with a one-cycle strobe, and forwards the payload on an output byte stream. If the frame carries a masking key, the payload is XORed with that key on the way through. The header and the key bytes themselves are never forwarded.

Both streams use valid/ready handshakes. A byte moves when valid and ready are high on the same rising edge. While header or key bytes are being read, the input is always ready. During the payload the input stream is tied straight to the output stream: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`, with no buffering. Back-pressure from downstream therefore stalls the upstream source directly, and the source must hold its byte while it waits.

The declared payload length is what ends a frame. `in_last` is looked at only to detect a frame that ends too early. Two error strobes flag malformed frames: a 64-bit length whose top bit is set, and a stream that ends before the frame is complete.

Top module: `ws_frame_parser`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `hdr_valid`, `err_len` and `err_short` are all 0.
- R2: The first header byte gives `hdr_fin` from bit 7, `hdr_rsv[2:0]` from bits 6..4 (bit 6 goes to `hdr_rsv[2]`) and `hdr_opcode` from bits 3..0. In the second byte, bit 7 is the masked flag (`hdr_masked`) and bits 6..0 are the short length.
- R3: A short length of 0 to 125 is the payload length itself. A value of 126 means the next 2 bytes hold the length, most significant byte first. A value of 127 means the next 8 bytes hold it in the same order. `hdr_len` shows the result.
- R4: When the masked flag is 1, four key bytes follow the length. Payload byte i leaves as the received byte XOR key byte (i mod 4), with key bytes counted in arrival order. When the flag is 0, payload bytes pass through unchanged.
- R5: `hdr_valid` pulses for exactly one cycle, in the cycle after the final header byte is accepted. The header sideband outputs keep their values until the first byte of the next frame is accepted.
- R6: `out_last` is 1 only on the final payload byte of a frame. A frame with zero payload length produces no output bytes but still pulses `hdr_valid`.
- R7: While a payload byte is offered, `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and a stalled output byte holds steady. Header and key bytes are accepted on every cycle.
- R8: If the first byte of a 64-bit length has bit 7 set, `err_len` pulses for one cycle. No `hdr_valid` follows, and the remaining bytes up to and including the one marked `in_last` are dropped without output.
- R9: `err_short` pulses for one cycle when `in_last` arrives on a header byte that does not complete a zero-length frame, or on a payload byte before the final one. The parser then expects a new frame.
- R10: The byte after a frame's final payload byte is parsed as the start of a new header, whether or not `in_last` was set. This also holds after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Parser accepts the input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last one of the stream segment |
| out_valid | output | 1 | Unmasked payload byte present |
| out_ready | input | 1 | Downstream accepts the payload byte |
| out_data | output | 8 | Unmasked payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| hdr_valid | output | 1 | One-cycle strobe: the header is complete |
| hdr_fin | output | 1 | Final-fragment flag |
| hdr_rsv | output | 3 | Reserved bits 1..3 |
| hdr_opcode | output | 4 | Frame opcode |
| hdr_masked | output | 1 | A masking key was present |
| hdr_len | output | 64 | Decoded payload length |
| err_len | output | 1 | Strobe: the 64-bit length has its top bit set |
| err_short | output | 1 | Strobe: the stream ended before the frame was complete |

## Verification
Random frames are drawn across all three length forms, with and without a key, and with random idle gaps and output stalls. Comparing the recovered plain payload against the bench's own copy separates key-byte ordering and rotation faults from length-decoding faults. Directed frames cover the cases random draws rarely hit: zero-length frames with and without a key, a 2-byte length that holds a small value, a 64-bit length above 255, a forbidden top length bit, and streams cut short inside the header and inside the payload. Two frames sent back to back with no end marker between them show that the end of a frame comes from the declared length and not from `in_last`.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] LEN7_EXT16 = 7'd126;
  localparam logic [6:0] LEN7_EXT64 = 7'd127;

  typedef enum logic [2:0] {
    ST_HDR0,
    ST_HDR1,
    ST_EXT16,
    ST_EXT64,
    ST_KEY,
    ST_PAYLOAD,
    ST_DISCARD
  } ws_state_e;
endpackage

// File: rtl/ws_hdr_ctrl.sv
module ws_hdr_ctrl
  import ws_pkg::*;
#(
  parameter int LEN_W     = 64,
  parameter int KEY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last_in,
  output ws_state_e         state,
  output logic              fin,
  output logic [2:0]        rsv,
  output logic [3:0]        opcode,
  output logic              masked,
  output logic [LEN_W-1:0]  len,
  output logic              rem_one,
  output logic              hdr_done,
  output logic              err_len,
  output logic              err_short
);
  localparam int EXT64_BYTES = LEN_W / BYTE_W;
  localparam int EXT16_BYTES = 2;
  localparam int CNT_W = (EXT64_BYTES > KEY_BYTES) ? $clog2(EXT64_BYTES) : $clog2(KEY_BYTES);

  ws_state_e st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] len_q, len_n, rem_q, rem_n;
  logic fin_q, fin_n, msk_q, msk_n;
  logic [2:0] rsv_q, rsv_n;
  logic [3:0] op_q, op_n;
  logic hv_q, hv_n, el_q, el_n, es_q, es_n;
  logic len_known, hdr_end, in_header;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; len_n = len_q; rem_n = rem_q;
    fin_n = fin_q; rsv_n = rsv_q; op_n = op_q; msk_n = msk_q;
    hv_n = 1'b0; el_n = 1'b0; es_n = 1'b0;
    len_known = 1'b0; hdr_end = 1'b0;
    in_header = (st_q == ST_HDR0) || (st_q == ST_HDR1) || (st_q == ST_EXT16) ||
                (st_q == ST_EXT64) || (st_q == ST_KEY);
    if (fire) begin
      unique case (st_q)
        ST_HDR0: begin
          fin_n = byte_in[7];
          rsv_n = byte_in[6:4];
          op_n  = byte_in[3:0];
          msk_n = 1'b0;
          len_n = '0;
          st_n  = ST_HDR1;
        end
        ST_HDR1: begin
          msk_n = byte_in[7];
          if (byte_in[6:0] == LEN7_EXT16) begin
            st_n  = ST_EXT16;
            cnt_n = CNT_W'(EXT16_BYTES - 1);
          end else if (byte_in[6:0] == LEN7_EXT64) begin
            st_n  = ST_EXT64;
            cnt_n = CNT_W'(EXT64_BYTES - 1);
          end else begin
            len_n     = LEN_W'(byte_in[6:0]);
            len_known = 1'b1;
          end
        end
        ST_EXT16, ST_EXT64: begin
          len_n = {len_q[LEN_W-BYTE_W-1:0], byte_in};
          if (st_q == ST_EXT64 && cnt_q == CNT_W'(EXT64_BYTES - 1) && byte_in[7]) begin
            el_n = 1'b1;
            st_n = last_in ? ST_HDR0 : ST_DISCARD;
          end else if (cnt_q == '0) begin
            len_known = 1'b1;
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        ST_KEY: begin
          if (cnt_q == '0) hdr_end = 1'b1;
          else cnt_n = cnt_q - 1'b1;
        end
        ST_PAYLOAD: begin
          rem_n = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            st_n = ST_HDR0;
          end else if (last_in) begin
            es_n = 1'b1;
            st_n = ST_HDR0;
          end
        end
        ST_DISCARD: begin
          if (last_in) st_n = ST_HDR0;
        end
        default: st_n = ST_HDR0;
      endcase

      if (len_known) begin
        if (msk_n) begin
          st_n  = ST_KEY;
          cnt_n = CNT_W'(KEY_BYTES - 1);
        end else begin
          hdr_end = 1'b1;
        end
      end

      if (hdr_end) begin
        rem_n = len_n;
        if (len_n == '0) begin
          hv_n = 1'b1;
          st_n = ST_HDR0;
        end else if (last_in) begin
          es_n = 1'b1;
          st_n = ST_HDR0;
        end else begin
          hv_n = 1'b1;
          st_n = ST_PAYLOAD;
        end
      end else if (in_header && last_in && !el_n) begin
        es_n = 1'b1;
        st_n = ST_HDR0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HDR0; cnt_q <= '0; len_q <= '0; rem_q <= '0;
      fin_q <= 1'b0; rsv_q <= '0; op_q <= '0; msk_q <= 1'b0;
      hv_q <= 1'b0; el_q <= 1'b0; es_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; len_q <= len_n; rem_q <= rem_n;
      fin_q <= fin_n; rsv_q <= rsv_n; op_q <= op_n; msk_q <= msk_n;
      hv_q <= hv_n; el_q <= el_n; es_q <= es_n;
    end
  end

  assign state     = st_q;
  assign fin       = fin_q;
  assign rsv       = rsv_q;
  assign opcode    = op_q;
  assign masked    = msk_q;
  assign len       = len_q;
  assign rem_one   = (rem_q == LEN_W'(1));
  assign hdr_done  = hv_q;
  assign err_len   = el_q;
  assign err_short = es_q;
endmodule

// File: rtl/ws_unmask.sv
module ws_unmask
  import ws_pkg::*;
#(
  parameter int KEY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              key_we,
  input  logic              adv,
  input  logic              masked,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  localparam int IDX_W = $clog2(KEY_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic [KEY_BYTES-1:0][BYTE_W-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (clr) idx_q <= '0;
    else if (key_we || adv)
      idx_q <= (idx_q == IDX_W'(KEY_BYTES - 1)) ? '0 : idx_q + 1'b1;
  end

  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[g] <= '0;
      else if (key_we && idx_q == IDX_W'(g)) key_q[g] <= din;
    end
  end

  assign dout = masked ? (din ^ key_q[idx_q]) : din;
endmodule

// File: rtl/ws_frame_parser.sv
module ws_frame_parser
  import ws_pkg::*;
#(
  parameter int LEN_W     = 64,
  parameter int KEY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              hdr_valid,
  output logic              hdr_fin,
  output logic [2:0]        hdr_rsv,
  output logic [3:0]        hdr_opcode,
  output logic              hdr_masked,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              err_len,
  output logic              err_short
);
  ws_state_e state;
  logic fire, rem_one, in_payload;

  assign in_payload = (state == ST_PAYLOAD);
  assign in_ready   = in_payload ? out_ready : 1'b1;
  assign fire       = in_valid && in_ready;
  assign out_valid  = in_valid && in_payload;
  assign out_last   = out_valid && rem_one;

  ws_hdr_ctrl #(.LEN_W(LEN_W), .KEY_BYTES(KEY_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .byte_in(in_data), .last_in(in_last),
    .state(state), .fin(hdr_fin), .rsv(hdr_rsv), .opcode(hdr_opcode),
    .masked(hdr_masked), .len(hdr_len), .rem_one(rem_one), .hdr_done(hdr_valid),
    .err_len(err_len), .err_short(err_short)
  );

  ws_unmask #(.KEY_BYTES(KEY_BYTES)) u_unmask (
    .clk(clk), .rst_n(rst_n),
    .clr(fire && state == ST_HDR0),
    .key_we(fire && state == ST_KEY),
    .adv(fire && in_payload),
    .masked(hdr_masked),
    .din(in_data), .dout(out_data)
  );
endmodule

// File: rtl/ws_parser_chk.sv
module ws_parser_chk #(
  parameter int LEN_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_data,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             hdr_valid,
  input logic             hdr_fin,
  input logic [2:0]       hdr_rsv,
  input logic [3:0]       hdr_opcode,
  input logic             hdr_masked,
  input logic [LEN_W-1:0] hdr_len,
  input logic             err_len,
  input logic             err_short
);
  a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready));
  a_r7_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);
  a_r8_no_header: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> (!hdr_valid && !err_short));
  a_r9_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |-> !out_valid);
  a_r6_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind ws_frame_parser ws_parser_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_ws_frame_parser.sv
module tb_ws_frame_parser;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last, hdr_valid, hdr_fin, hdr_masked, err_len, err_short;
  logic [7:0] out_data;
  logic [2:0] hdr_rsv;
  logic [3:0] hdr_opcode;
  logic [63:0] hdr_len;

  always #5 clk = ~clk;

  ws_frame_parser dut (.*);

  int total = 0, bad = 0;
  bit done = 0, stall_en = 0, gap_en = 0;
  bit [7:0] txq[$];
  bit txl[$];
  bit [8:0] exp_out[$], got_out[$];
  bit [72:0] exp_hdr[$], got_hdr[$];
  int exp_el = 0, exp_es = 0, n_el = 0, n_es = 0, stalls = 0, rdy_viol = 0;

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) got_out.push_back({out_last, out_data});
    if (out_valid && !out_ready) stalls++;
    if (in_valid && !in_ready && !out_valid) rdy_viol++;
    if (hdr_valid) got_hdr.push_back({hdr_fin, hdr_rsv, hdr_opcode, hdr_masked, hdr_len});
    if (err_len) n_el++;
    if (err_short) n_es++;
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic build(input bit fin, input bit [2:0] rsv, input bit [3:0] op, input bit msk,
                       input int form, input longint unsigned len, input bit end_last);
    bit [7:0] key[4];
    bit [7:0] p;
    int start = txq.size();
    txq.push_back({fin, rsv, op});
    if (form == 0) txq.push_back({msk, len[6:0]});
    else if (form == 1) begin
      txq.push_back({msk, 7'd126});
      txq.push_back(len[15:8]); txq.push_back(len[7:0]);
    end else begin
      txq.push_back({msk, 7'd127});
      for (int b = 7; b >= 0; b--) txq.push_back(len[b*8 +: 8]);
    end
    for (int k = 0; k < 4; k++) key[k] = 8'($urandom);
    if (msk) for (int k = 0; k < 4; k++) txq.push_back(key[k]);
    for (longint unsigned i = 0; i < len; i++) begin
      p = 8'($urandom);
      txq.push_back(msk ? (p ^ key[i % 4]) : p);
      exp_out.push_back({(i == len - 1), p});
    end
    for (int i = start; i < txq.size(); i++) txl.push_back(end_last && (i == txq.size() - 1));
    exp_hdr.push_back({fin, rsv, op, msk, len});
  endtask

  task automatic cut(input int n);
    while (txq.size() > n) begin void'(txq.pop_back()); void'(txl.pop_back()); end
    txl[n-1] = 1;
  endtask

  task automatic send_byte(input bit [7:0] b, input bit l);
    if (gap_en && ($urandom % 4) == 0) begin
      in_valid = 0; @(posedge clk); #1;
    end
    in_valid = 1; in_data = b; in_last = l;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
  endtask

  task automatic flush_and_check(input string note);
    bit [72:0] lh;
    for (int i = 0; i < txq.size(); i++) send_byte(txq[i], txl[i]);
    repeat (4) @(posedge clk);
    #1;
    chk(got_hdr.size() == exp_hdr.size(), "R5", got_hdr.size(), exp_hdr.size());
    for (int i = 0; i < got_hdr.size() && i < exp_hdr.size(); i++) begin
      chk(got_hdr[i][72:64] == exp_hdr[i][72:64], "R2", got_hdr[i][72:64], exp_hdr[i][72:64]);
      chk(got_hdr[i][63:0] == exp_hdr[i][63:0], "R3", got_hdr[i][63:0], exp_hdr[i][63:0]);
    end
    if (exp_hdr.size() > 0 && exp_el == 0 && exp_es == 0) begin
      lh = exp_hdr[exp_hdr.size()-1];
      chk({hdr_fin, hdr_rsv, hdr_opcode, hdr_masked, hdr_len} == lh, "R5",
          hdr_len, lh[63:0]);
    end
    chk(got_out.size() == exp_out.size(), "R6", got_out.size(), exp_out.size());
    for (int i = 0; i < got_out.size() && i < exp_out.size(); i++) begin
      chk(got_out[i][7:0] == exp_out[i][7:0], "R4", got_out[i][7:0], exp_out[i][7:0]);
      chk(got_out[i][8] == exp_out[i][8], "R6", got_out[i][8], exp_out[i][8]);
    end
    chk(n_el == exp_el, "R8", n_el, exp_el);
    chk(n_es == exp_es, "R9", n_es, exp_es);
    chk(rdy_viol == 0, "R7", rdy_viol, 0);
    if (bad > 0) $display("  after %s", note);
    txq.delete(); txl.delete(); exp_out.delete(); got_out.delete();
    exp_hdr.delete(); got_hdr.delete();
    exp_el = 0; exp_es = 0; n_el = 0; n_es = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int form;
    longint unsigned len;
    void'($urandom(32'd20417));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1, "R1", in_ready, 1);
    chk(out_valid == 0 && hdr_valid == 0, "R1", {out_valid, hdr_valid}, 0);
    chk(err_len == 0 && err_short == 0, "R1", {err_len, err_short}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R6 zero-length frames, unmasked and masked
    build(1, 3'b000, 4'h9, 0, 0, 0, 1); flush_and_check("zero unmasked");
    build(1, 3'b101, 4'hA, 1, 0, 0, 1); flush_and_check("zero masked");
    // R3 16-bit form carrying a small value, 64-bit form above 255
    build(0, 3'b010, 4'h2, 1, 1, 5, 1); flush_and_check("ext16 small");
    build(1, 3'b001, 4'h1, 1, 2, 300, 1); flush_and_check("ext64");
    // R10 back-to-back without in_last between frames
    build(0, 3'b000, 4'h1, 1, 0, 7, 0);
    build(1, 3'b000, 4'h0, 0, 1, 130, 1); flush_and_check("back to back");

    // Random frames, R4 R7 with gaps and stalls
    gap_en = 1;
    for (int f = 0; f < 30; f++) begin
      stall_en = (f >= 10);
      form = $urandom % 3;
      len = (form == 0) ? ($urandom % 126) : ($urandom % 200);
      build(1'($urandom), 3'($urandom), 4'($urandom), 1'($urandom), form, len, 1'($urandom));
      flush_and_check("random");
    end
    chk(stalls > 0, "R7", stalls, 1);

    // R8 top length bit set, then recovery (R10)
    txq = '{8'h82, 8'hFF, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h11, 8'h22, 8'h33};
    txl = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};
    exp_el = 1;
    flush_and_check("len msb");
    build(1, 3'b000, 4'h2, 1, 0, 9, 1); flush_and_check("after len err");

    // R9 truncated inside payload
    build(1, 3'b000, 4'h2, 0, 0, 10, 1);
    cut(7);
    repeat (5) void'(exp_out.pop_back());
    exp_es = 1;
    flush_and_check("short payload");
    // R9 truncated inside header
    build(1, 3'b000, 4'h2, 1, 1, 40, 1);
    cut(3);
    exp_out.delete(); void'(exp_hdr.pop_back());
    exp_es = 1;
    flush_and_check("short header");
    build(0, 3'b111, 4'hF, 1, 0, 3, 1); flush_and_check("after short");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule